// File: doc/BRIEF.md
# Converter Fault Protection Sequencer

This block decides, once per switching cycle, whether a regulator's power stage may keep switching. A cycle tick marks the end of every converter cycle. On each tick while the stage is active, the block samples an overcurrent comparator and an overvoltage comparator and updates two counters.

The overcurrent counter is a saturating leaky bucket. It rises quickly on faulty cycles and drains slowly on clean ones. The overvoltage counter measures the current run of faulty cycles without a break. Either counter reaching its limit stops the stage, and the block then runs a restart sequence.

After an overcurrent stop, the block waits a fixed number of cycles and then starts a new soft-start ramp. After an overvoltage stop, it waits for the output to sag below the undervoltage level. It then lets a number of ramp periods pass with the stage held off, and only then starts a real soft-start. Dropping the enable input stops everything and clears all counters and timers.

Top module: `fps_seq`

## Requirements
- R1: While `en_i` is low, or during reset, all state is cleared. On the clock after `en_i` is sampled low, `pwm_en_o`=0, `ss_active_o`=0 and `ss_clear_o`=1.
- R2: On the first clock with `en_i` high after being off, the block enters soft-start: `pwm_en_o`=1 and `ss_active_o`=1. Every start of switching begins in soft-start.
- R3: Soft-start lasts exactly SS_TICKS ticks. After the SS_TICKS-th tick, `ss_active_o` falls while `pwm_en_o` stays high.
- R4: On each tick while switching, the overcurrent counter (OC_W bits) adds 2 if `oc_i`=1. Otherwise it subtracts 1, with a floor at 0. An overcurrent pattern of one cycle in three never trips it.
- R5: The addition saturates at all-ones, so 14+2 gives 15 and does not wrap. The counter reaching all-ones is a trip: `pwm_en_o`=0 and `ss_clear_o`=1 on the clock after that tick.
- R6: After an overcurrent trip, switching resumes in soft-start after exactly RETRY_TICKS further ticks.
- R7: `ov_i`=1 on OV_LIMIT consecutive ticks while switching turns `pwm_en_o` off. Any tick with `ov_i`=0 restarts the run from zero.
- R8: After an overvoltage trip, the block waits with `ss_clear_o`=1 until a tick with `uv_i`=1. It then spends DUMMY_RAMPS×SS_TICKS ticks with `pwm_en_o`=0 and `ss_clear_o`=0, and then enters soft-start.
- R9: If both trips occur on the same tick, the overcurrent path wins: the restart comes RETRY_TICKS ticks later and does not wait for `uv_i`.
- R10: Apart from `en_i` going low, outputs change only on the clock that samples a tick. With `en_i` high and no tick, a switching stage stays switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low forces shutdown |
| tick_i | input | 1 | One-clock pulse at the end of each converter cycle |
| oc_i | input | 1 | Overcurrent comparator, sampled on tick |
| ov_i | input | 1 | Overvoltage comparator, sampled on tick |
| uv_i | input | 1 | Output below undervoltage level, sampled on tick |
| pwm_en_o | output | 1 | Power stage may switch |
| ss_active_o | output | 1 | Soft-start ramp in progress with switching |
| ss_clear_o | output | 1 | Hold the soft-start ramp at its reset value |

## Verification
Every output comes straight from the state register. Each effect of a sampled tick or enable level is therefore visible exactly one clock after the edge that samples it, and never earlier. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge, and outputs are compared 1 ns after every rising edge, so each result is checked in the very cycle it is due. The stimulus holds ticks apart by an idle clock, which keeps the one-clock latency apart from tick pacing.

// File: rtl/fps_pkg.sv
package fps_pkg;
   typedef enum logic [2:0] {
      ST_OFF      = 3'd0,
      ST_RAMP     = 3'd1,
      ST_RUN      = 3'd2,
      ST_OC_HOLD  = 3'd3,
      ST_OV_WAIT  = 3'd4,
      ST_OV_DUMMY = 3'd5
   } fps_state_e;
endpackage

// File: rtl/fps_oc_bucket.sv
module fps_oc_bucket #(
   parameter int W  = 4,
   parameter int UP = 2,
   parameter int DN = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         step_i,
   input  logic         hit_i,
   output logic [W-1:0] cnt_o,
   output logic         trip_o
);
   localparam int MAXV = (1 << W) - 1;

   if (W < 2 || W > 16) begin : g_bad_w
      $error("fps_oc_bucket: W out of range");
   end
   if (UP < 1 || UP >= MAXV || DN < 1 || DN >= MAXV) begin : g_bad_step
      $error("fps_oc_bucket: step sizes out of range");
   end

   logic [W-1:0] cnt_q, nxt;
   logic [W:0]   up_sum;

   always_comb begin
      up_sum = {1'b0, cnt_q} + (W+1)'(UP);
      if (hit_i)
         nxt = (up_sum >= (W+1)'(MAXV)) ? W'(MAXV) : up_sum[W-1:0];
      else
         nxt = (cnt_q >= W'(DN)) ? (cnt_q - W'(DN)) : '0;
   end

   assign trip_o = step_i && (nxt == W'(MAXV));
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr_i || trip_o)  cnt_q <= '0;
      else if (step_i)           cnt_q <= nxt;
   end
endmodule

// File: rtl/fps_run_counter.sv
module fps_run_counter #(
   parameter int LIMIT = 32,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   input  logic          hit_i,
   output logic [CW-1:0] cnt_o,
   output logic          trip_o
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("fps_run_counter: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign trip_o = step_i && hit_i && (cnt_q == CW'(LIMIT - 1));
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (clr_i || trip_o)               cnt_q <= '0;
      else if (step_i && !hit_i)              cnt_q <= '0;
      else if (step_i)                        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/fps_tick_timer.sv
module fps_tick_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic done_o
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("fps_tick_timer: LIMIT must be positive");
   end

   if (LIMIT == 1) begin : g_single
      assign done_o = inc_i;
   end else begin : g_count
      localparam int CW = $clog2(LIMIT);
      logic [CW-1:0] cnt_q;

      assign done_o = inc_i && (cnt_q == CW'(LIMIT - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 cnt_q <= '0;
         else if (clr_i || done_o)   cnt_q <= '0;
         else if (inc_i)             cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fps_seq.sv
module fps_seq #(
   parameter int OC_W        = 4,
   parameter int OC_UP       = 2,
   parameter int OC_DN       = 1,
   parameter int OV_LIMIT    = 32,
   parameter int RETRY_TICKS = 16,
   parameter int SS_TICKS    = 4125,
   parameter int DUMMY_RAMPS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic tick_i,
   input  logic oc_i,
   input  logic ov_i,
   input  logic uv_i,
   output logic pwm_en_o,
   output logic ss_active_o,
   output logic ss_clear_o
);
   import fps_pkg::*;

   localparam int OV_CW = $clog2(OV_LIMIT + 1);

   if (SS_TICKS < 1 || RETRY_TICKS < 1 || DUMMY_RAMPS < 1) begin : g_bad_timing
      $error("fps_seq: timing parameters must be positive");
   end

   fps_state_e st_q, st_d;

   logic live, fault_step, oc_trip, ov_trip;
   logic ss_inc, ss_clr, ss_done;
   logic rt_inc, rt_clr, rt_done;
   logic dm_inc, dm_clr, dm_done;
   logic [OC_W-1:0]  oc_cnt;
   logic [OV_CW-1:0] ov_cnt;

   assign live       = (st_q == ST_RAMP) || (st_q == ST_RUN);
   assign fault_step = en_i && tick_i && live;

   fps_oc_bucket #(.W(OC_W), .UP(OC_UP), .DN(OC_DN)) u_oc (
      .clk(clk), .rst_n(rst_n), .clr_i(!en_i || !live),
      .step_i(fault_step), .hit_i(oc_i),
      .cnt_o(oc_cnt), .trip_o(oc_trip)
   );

   fps_run_counter #(.LIMIT(OV_LIMIT)) u_ov (
      .clk(clk), .rst_n(rst_n), .clr_i(!en_i || !live),
      .step_i(fault_step), .hit_i(ov_i),
      .cnt_o(ov_cnt), .trip_o(ov_trip)
   );

   assign ss_inc = en_i && tick_i && ((st_q == ST_RAMP) || (st_q == ST_OV_DUMMY));
   assign ss_clr = !en_i || !((st_q == ST_RAMP) || (st_q == ST_OV_DUMMY))
                   || oc_trip || ov_trip;

   fps_tick_timer #(.LIMIT(SS_TICKS)) u_ss (
      .clk(clk), .rst_n(rst_n), .clr_i(ss_clr), .inc_i(ss_inc), .done_o(ss_done)
   );

   assign rt_inc = en_i && tick_i && (st_q == ST_OC_HOLD);
   assign rt_clr = !en_i || (st_q != ST_OC_HOLD);

   fps_tick_timer #(.LIMIT(RETRY_TICKS)) u_retry (
      .clk(clk), .rst_n(rst_n), .clr_i(rt_clr), .inc_i(rt_inc), .done_o(rt_done)
   );

   assign dm_inc = ss_done && (st_q == ST_OV_DUMMY);
   assign dm_clr = !en_i || (st_q != ST_OV_DUMMY);

   fps_tick_timer #(.LIMIT(DUMMY_RAMPS)) u_dummy (
      .clk(clk), .rst_n(rst_n), .clr_i(dm_clr), .inc_i(dm_inc), .done_o(dm_done)
   );

   always_comb begin
      st_d = st_q;
      if (!en_i) begin
         st_d = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF:      st_d = ST_RAMP;
            ST_RAMP,
            ST_RUN: begin
               if (oc_trip)                        st_d = ST_OC_HOLD;
               else if (ov_trip)                   st_d = ST_OV_WAIT;
               else if (st_q == ST_RAMP && ss_done) st_d = ST_RUN;
            end
            ST_OC_HOLD:  if (rt_done)            st_d = ST_RAMP;
            ST_OV_WAIT:  if (tick_i && uv_i)     st_d = ST_OV_DUMMY;
            ST_OV_DUMMY: if (dm_done)            st_d = ST_RAMP;
            default:                             st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= st_d;
   end

   assign pwm_en_o    = live;
   assign ss_active_o = (st_q == ST_RAMP);
   assign ss_clear_o  = (st_q == ST_OFF) || (st_q == ST_OC_HOLD) || (st_q == ST_OV_WAIT);
endmodule

// File: rtl/fps_seq_chk.sv
module fps_seq_chk #(
   parameter int OC_W     = 4,
   parameter int OV_LIMIT = 32,
   localparam int OV_CW   = $clog2(OV_LIMIT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_i,
   input logic             tick_i,
   input logic             oc_i,
   input logic             ov_i,
   input logic             pwm_en_o,
   input logic             ss_active_o,
   input logic             ss_clear_o,
   input logic [OC_W-1:0]  oc_cnt,
   input logic [OV_CW-1:0] ov_cnt
);
   a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!pwm_en_o && !ss_active_o && ss_clear_o));

   a_r2_start_in_ramp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_en_o) |-> ss_active_o);

   a_r4_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && tick_i && pwm_en_o && !oc_i && oc_cnt == '0) |=> (oc_cnt == '0));

   a_r5_no_stored_top: assert property (@(posedge clk) disable iff (!rst_n)
      oc_cnt != {OC_W{1'b1}});

   a_r7_run_broken: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && tick_i && pwm_en_o && !ov_i) |=> (ov_cnt == '0));

   a_r10_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !tick_i && pwm_en_o) |=> pwm_en_o);
endmodule

bind fps_seq fps_seq_chk #(.OC_W(OC_W), .OV_LIMIT(OV_LIMIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i), .oc_i(oc_i), .ov_i(ov_i),
   .pwm_en_o(pwm_en_o), .ss_active_o(ss_active_o), .ss_clear_o(ss_clear_o),
   .oc_cnt(oc_cnt), .ov_cnt(ov_cnt)
);

// File: tb/sim_fps_seq.sv
`timescale 1ns/1ps
module sim_fps_seq;
   localparam int SS  = 6;
   localparam int RT  = 16;
   localparam int OVL = 32;
   localparam int DM  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, tick = 1'b0, oc = 1'b0, ov = 1'b0, uv = 1'b0;
   logic pwm_en, ss_active, ss_clear;

   always #2.5 clk = ~clk;

   fps_seq #(.OV_LIMIT(OVL), .RETRY_TICKS(RT), .SS_TICKS(SS), .DUMMY_RAMPS(DM)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick), .oc_i(oc), .ov_i(ov), .uv_i(uv),
      .pwm_en_o(pwm_en), .ss_active_o(ss_active), .ss_clear_o(ss_clear)
   );

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   // behavioural model: phase 0 off,1 ramp,2 run,3 oc hold,4 ov wait,5 ov dummy
   int ms = 0, moc = 0, mov = 0, mss = 0, mrt = 0, mdm = 0, noc = 0, nov = 0;

   always @(posedge clk) begin
      if (!rst_n || !en) begin
         ms = 0; moc = 0; mov = 0; mss = 0; mrt = 0; mdm = 0;
      end else if (ms == 0) begin
         ms = 1; mss = 0;
      end else if (tick) begin
         if (ms == 1 || ms == 2) begin
            noc = oc ? ((moc + 2 > 15) ? 15 : moc + 2) : ((moc > 0) ? moc - 1 : 0);
            nov = ov ? mov + 1 : 0;
            if (noc == 15) begin
               ms = 3; moc = 0; mov = 0; mss = 0; mrt = 0;
            end else if (nov == OVL) begin
               ms = 4; moc = 0; mov = 0; mss = 0;
            end else begin
               moc = noc; mov = nov;
               if (ms == 1) begin
                  mss++;
                  if (mss == SS) begin ms = 2; mss = 0; end
               end
            end
         end else if (ms == 3) begin
            mrt++;
            if (mrt == RT) begin ms = 1; mrt = 0; end
         end else if (ms == 4) begin
            if (uv) begin ms = 5; mss = 0; mdm = 0; end
         end else if (ms == 5) begin
            mss++;
            if (mss == SS) begin
               mss = 0; mdm++;
               if (mdm == DM) begin ms = 1; mdm = 0; end
            end
         end
      end
   end

   task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0t pwm/ssa/ssc actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   always begin
      @(posedge clk);
      #1;
      if (!done)
         check({pwm_en, ss_active, ss_clear},
               {(ms == 1 || ms == 2), (ms == 1), (ms == 0 || ms == 3 || ms == 4)}, cur_req);
   end

   task automatic cyc(input logic o, input logic v, input logic u);
      @(negedge clk);
      tick = 1'b1; oc = o; ov = v; uv = u;
      @(negedge clk);
      tick = 1'b0; oc = 1'b0; ov = 1'b0; uv = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cur_req = "R1";
      idle(4);
      check({pwm_en, ss_active, ss_clear}, 3'b001, "R1");
      rst_n = 1'b1;
      idle(3);
      cur_req = "R2";
      en = 1'b1;
      idle(3);
      cur_req = "R3";
      repeat (10) cyc(0, 0, 0);
      cur_req = "R4";
      repeat (12) begin cyc(1, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); end
      cur_req = "R5";
      repeat (8) cyc(1, 0, 0);
      cur_req = "R6";
      repeat (24) cyc(0, 0, 0);
      cur_req = "R7";
      repeat (31) cyc(0, 1, 0);
      cyc(0, 0, 0);
      repeat (32) cyc(0, 1, 0);
      cur_req = "R8";
      repeat (5) cyc(0, 0, 0);
      cyc(0, 0, 1);
      repeat (24) cyc(0, 0, 0);
      cur_req = "R9";
      repeat (24) cyc(0, 1, 0);
      repeat (8) cyc(1, 1, 0);
      repeat (24) cyc(0, 0, 0);
      cur_req = "R10";
      repeat (6) begin cyc(1, 0, 0); idle(5); end
      repeat (10) begin cyc(0, 0, 0); idle(3); end
      cur_req = "R1";
      cyc(1, 0, 0);
      en = 1'b0;
      idle(4);
      en = 1'b1;
      idle(3);
      repeat (4) cyc(0, 0, 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired in %s", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule